// File: doc/BRIEF.md
# Width-Configurable Serial Data Queue

This block is the data queue that sits between a serial-port shift engine and the processor bus, once on the transmit side and once on the receive side. It holds a fixed store of 256 bytes. Entries can be one, two or four bytes wide, so the queue holds 256, 128 or 64 entries. Data is pushed on one side and popped in arrival order on the other. Narrow entries come out zero-extended on the 32-bit read port.

Software steers the queue through two writes. The operation write carries a clear bit and a run bit. The control write carries the entry width and a threshold. A 10-bit status word reports the fill level together with full and empty flags. Two event outputs report when the threshold has been reached and whether a receive overflow has occurred. A parameter selects the receive or transmit flavour, and this choice sets the sense of the threshold comparison and whether overflow can be recorded.

Top module: `spi_width_fifo`

## Requirements
- R1: After reset the status word reads 10'h200 (empty flag at bit 9 set, full flag at bit 8 clear, level in bits 7:0 zero). The queue is stopped, the overflow event is low, the width is byte and the threshold is 128.
- R2: Entries pop out in the order they were pushed. The read port presents the head entry, and bytes above the entry width read as zero.
- R3: The control write takes the width code in bits 1:0 (0 byte, 1 two bytes, 2 four bytes, 3 treated as four bytes) and the threshold in bits 9:2. The level counts entries of the active width, and the full flag is set at 256, 128 or 64 entries.
- R4: In byte mode a queue holding 256 entries reports level bits 7:0 as zero with the full flag set (status 10'h100).
- R5: A new width code takes effect only at the next clear operation. Until then the queue keeps using the old width.
- R6: An operation write takes clear in bit 0 and run in bit 1. Clear zeroes the pointers, the level and the overflow event. The run bit starts or stops the queue. Stopping keeps the stored contents, and they are still there after a restart.
- R7: While the queue is stopped, pushes and pops have no effect.
- R8: A push while full leaves the level and contents unchanged. A pop while empty leaves the queue empty.
- R9: On the receive flavour, a push while full sets a sticky overflow event that only a clear removes. The transmit flavour never raises the event.
- R10: The threshold event is high on the receive flavour when the level is at least the threshold, and on the transmit flavour when the level is at most the threshold.
- R11: A push and a pop in the same cycle on a queue that is neither full nor empty leave the level unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opWrEn | input | 1 | Operation write strobe |
| opData | input | 2 | Operation value: bit 0 clear, bit 1 run |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlData | input | 10 | Control value: bits 1:0 width code, bits 9:2 threshold |
| pushEn | input | 1 | Push one entry |
| pushData | input | 32 | Entry to push, low bytes used for narrow widths |
| popEn | input | 1 | Pop the head entry |
| popData | output | 32 | Head entry, zero-extended |
| statusWord | output | 10 | Bit 9 empty, bit 8 full, bits 7:0 level |
| evThreshold | output | 1 | Threshold reached |
| evOverflow | output | 1 | Sticky receive overflow |

## Verification
The properties assume that a clear operation is never issued in the same cycle as a control write. They also assume that the hold checks on the full and empty conditions are only relied on in cycles without an operation write. The stimulus drives one kind of register write per cycle and applies push and pop only on cycles with no operation write. This keeps every property inside those assumptions. The one same-cycle push and pop is issued on a queue that is neither full nor empty.

// File: rtl/swf_pkg.sv
package swf_pkg;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_WIDE = 2'd3
  } widthSel_e;

  // strobes from control to storage
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       clear;
    logic [2:0] stepBytes;
  } storeCmd_t;

  function automatic logic [1:0] widthShift(widthSel_e w);
    case (w)
      WID_BYTE: return 2'd0;
      WID_HALF: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] widthBytes(widthSel_e w);
    return 3'(1) << widthShift(w);
  endfunction

endpackage

// File: rtl/swf_ctrl.sv
module swf_ctrl
  import swf_pkg::*;
#(
  parameter int STORE_BYTES = 256,
  parameter int THR_W       = 8,
  parameter bit RX_SIDE     = 1'b1,
  localparam int CNT_W      = $clog2(STORE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opWrEn,
  input  logic             opReset,
  input  logic             opStart,
  input  logic             ctrlWrEn,
  input  widthSel_e        ctrlWidth,
  input  logic [THR_W-1:0] ctrlThr,
  input  logic             pushEn,
  input  logic             popEn,
  output storeCmd_t        cmd,
  output logic [CNT_W-1:0] count,
  output logic             isFull,
  output logic             isEmpty,
  output logic             overflow,
  output logic             running,
  output logic [THR_W-1:0] thrReg
);

  localparam logic [CNT_W-1:0] STORE_ENTRIES = CNT_W'(STORE_BYTES);
  localparam logic [THR_W-1:0] THR_RESET     = THR_W'(STORE_BYTES / 2);

  widthSel_e        activeWidth;
  widthSel_e        pendingWidth;
  logic [CNT_W-1:0] maxEntries;
  logic             clearNow;
  logic             doPush;
  logic             doPop;

  assign maxEntries = STORE_ENTRIES >> widthShift(activeWidth);
  assign isFull     = (count == maxEntries);
  assign isEmpty    = (count == '0);
  assign clearNow   = opWrEn && opReset;
  assign doPush     = running && pushEn && !isFull && !clearNow;
  assign doPop      = running && popEn && !isEmpty && !clearNow;

  always_comb begin
    cmd.push      = doPush;
    cmd.pop       = doPop;
    cmd.clear     = clearNow;
    cmd.stepBytes = widthBytes(activeWidth);
  end

  // software-visible settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingWidth <= WID_BYTE;
      thrReg       <= THR_RESET;
      running      <= 1'b0;
    end else begin
      if (ctrlWrEn) begin
        pendingWidth <= ctrlWidth;
        thrReg       <= ctrlThr;
      end
      if (opWrEn) begin
        running <= opStart;
      end
    end
  end

  // occupancy, active width and overflow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeWidth <= WID_BYTE;
      count       <= '0;
      overflow    <= 1'b0;
    end else if (clearNow) begin
      activeWidth <= pendingWidth;
      count       <= '0;
      overflow    <= 1'b0;
    end else begin
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (RX_SIDE && running && pushEn && isFull) begin
        overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/swf_store.sv
module swf_store
  import swf_pkg::*;
#(
  parameter int STORE_BYTES = 256,
  parameter int DATA_W      = 32,
  localparam int ADDR_W     = $clog2(STORE_BYTES),
  localparam int LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCmd_t         cmd,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);

  logic [7:0]        mem [STORE_BYTES];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  // byte pointers wrap naturally since every width divides the store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + ADDR_W'(cmd.stepBytes);
      if (cmd.pop)  rdPtr <= rdPtr + ADDR_W'(cmd.stepBytes);
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.push) begin
      for (int l = 0; l < LANES; l++) begin
        if (3'(l) < cmd.stepBytes) begin
          mem[wrPtr + ADDR_W'(l)] <= pushData[8*l +: 8];
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign popData[8*g +: 8] = (3'(g) < cmd.stepBytes) ? mem[rdPtr + ADDR_W'(g)] : 8'h00;
  end

endmodule

// File: rtl/swf_status.sv
module swf_status #(
  parameter int CNT_W   = 9,
  parameter int THR_W   = 8,
  parameter int LVL_W   = 8,
  parameter bit RX_SIDE = 1'b1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             isFull,
  input  logic             isEmpty,
  input  logic [THR_W-1:0] thrReg,
  output logic [LVL_W+1:0] statusWord,
  output logic             evThreshold
);

  logic [CNT_W-1:0] thrExt;

  assign thrExt     = CNT_W'(thrReg);
  assign statusWord = {isEmpty, isFull, count[LVL_W-1:0]};

  if (RX_SIDE) begin : g_rxThr
    assign evThreshold = (count >= thrExt);
  end else begin : g_txThr
    assign evThreshold = (count <= thrExt);
  end

endmodule

// File: rtl/spi_width_fifo.sv
module spi_width_fifo
  import swf_pkg::*;
#(
  parameter int STORE_BYTES = 256,
  parameter int DATA_W      = 32,
  parameter int THR_W       = 8,
  parameter int LVL_W       = 8,
  parameter bit RX_SIDE     = 1'b1,
  localparam int CNT_W      = $clog2(STORE_BYTES) + 1,
  localparam int CTRL_W     = THR_W + 2,
  localparam int STAT_W     = LVL_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWrEn,
  input  logic [1:0]        opData,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic [STAT_W-1:0] statusWord,
  output logic              evThreshold,
  output logic              evOverflow
);

  storeCmd_t        cmd;
  logic [CNT_W-1:0] count;
  logic             isFull;
  logic             isEmpty;
  logic             running;
  logic [THR_W-1:0] thrReg;

  swf_ctrl #(
    .STORE_BYTES(STORE_BYTES),
    .THR_W      (THR_W),
    .RX_SIDE    (RX_SIDE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opWrEn   (opWrEn),
    .opReset  (opData[0]),
    .opStart  (opData[1]),
    .ctrlWrEn (ctrlWrEn),
    .ctrlWidth(widthSel_e'(ctrlData[1:0])),
    .ctrlThr  (ctrlData[CTRL_W-1:2]),
    .pushEn   (pushEn),
    .popEn    (popEn),
    .cmd      (cmd),
    .count    (count),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .overflow (evOverflow),
    .running  (running),
    .thrReg   (thrReg)
  );

  swf_store #(
    .STORE_BYTES(STORE_BYTES),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .pushData(pushData),
    .popData (popData)
  );

  swf_status #(
    .CNT_W  (CNT_W),
    .THR_W  (THR_W),
    .LVL_W  (LVL_W),
    .RX_SIDE(RX_SIDE)
  ) u_status (
    .count      (count),
    .isFull     (isFull),
    .isEmpty    (isEmpty),
    .thrReg     (thrReg),
    .statusWord (statusWord),
    .evThreshold(evThreshold)
  );

endmodule

// File: rtl/spi_width_fifo_chk.sv
module spi_width_fifo_chk #(
  parameter int LVL_W   = 8,
  parameter bit RX_SIDE = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             opWrEn,
  input logic [1:0]       opData,
  input logic             pushEn,
  input logic             popEn,
  input logic             running,
  input logic [LVL_W+1:0] statusWord,
  input logic             evOverflow
);

  logic fullFlag;
  logic emptyFlag;
  assign fullFlag  = statusWord[LVL_W];
  assign emptyFlag = statusWord[LVL_W+1];

  assert_empty_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> (statusWord[LVL_W-1:0] == '0) && !fullFlag);

  assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !opWrEn) |=> $stable(statusWord));

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && pushEn && !popEn && !opWrEn) |=> fullFlag && $stable(statusWord[LVL_W-1:0]));

  assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && popEn && !pushEn && !opWrEn) |=> emptyFlag);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evOverflow && !(opWrEn && opData[0])) |=> evOverflow);

  assert_overflow_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (RX_SIDE && running && fullFlag && pushEn && !opWrEn) |=> evOverflow);

  assert_tx_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    !RX_SIDE |-> !evOverflow);

endmodule

bind spi_width_fifo spi_width_fifo_chk #(
  .LVL_W  (LVL_W),
  .RX_SIDE(RX_SIDE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opWrEn    (opWrEn),
  .opData    (opData),
  .pushEn    (pushEn),
  .popEn     (popEn),
  .running   (running),
  .statusWord(statusWord),
  .evOverflow(evOverflow)
);

// File: tb/test_spi_width_fifo.sv
`timescale 1ns/1ps
module test_spi_width_fifo;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  // two instances: receive flavour (index 0) and transmit flavour (index 1)
  logic [1:0]  opWrEn, ctrlWrEn, pushEn, popEn;
  logic [1:0]  opData   [2];
  logic [9:0]  ctrlData [2];
  logic [31:0] pushData [2];
  logic [31:0] popData  [2];
  logic [9:0]  statusWord [2];
  logic [1:0]  evThreshold, evOverflow;

  spi_width_fifo #(.RX_SIDE(1'b1)) i_spi_width_fifo (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn[0]), .opData(opData[0]),
    .ctrlWrEn(ctrlWrEn[0]), .ctrlData(ctrlData[0]), .pushEn(pushEn[0]),
    .pushData(pushData[0]), .popEn(popEn[0]), .popData(popData[0]),
    .statusWord(statusWord[0]), .evThreshold(evThreshold[0]), .evOverflow(evOverflow[0]));

  spi_width_fifo #(.RX_SIDE(1'b0)) i_spi_width_fifo_tx (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn[1]), .opData(opData[1]),
    .ctrlWrEn(ctrlWrEn[1]), .ctrlData(ctrlData[1]), .pushEn(pushEn[1]),
    .pushData(pushData[1]), .popEn(popEn[1]), .popData(popData[1]),
    .statusWord(statusWord[1]), .evThreshold(evThreshold[1]), .evOverflow(evOverflow[1]));

  int nChecks = 0;
  int nFail   = 0;

  // width code, pushed value, expected popped value
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'h123456A5, 32'h000000A5},
    {2'd0, 32'hFFFFFF00, 32'h00000000},
    {2'd1, 32'hDEADBEEF, 32'h0000BEEF},
    {2'd1, 32'h00008001, 32'h00008001},
    {2'd2, 32'hCAFEF00D, 32'hCAFEF00D},
    {2'd2, 32'h00000001, 32'h00000001},
    {2'd3, 32'h87654321, 32'h87654321},
    {2'd0, 32'h0000007E, 32'h0000007E}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic opWrite(int s, logic clr, logic run);
    opWrEn[s] = 1'b1; opData[s] = {run, clr};
    @(negedge clk);
    opWrEn[s] = 1'b0; opData[s] = 2'b00;
  endtask

  task automatic ctrlWrite(int s, logic [1:0] w, logic [7:0] thr);
    ctrlWrEn[s] = 1'b1; ctrlData[s] = {thr, w};
    @(negedge clk);
    ctrlWrEn[s] = 1'b0;
  endtask

  task automatic push(int s, logic [31:0] d);
    pushEn[s] = 1'b1; pushData[s] = d;
    @(negedge clk);
    pushEn[s] = 1'b0;
  endtask

  task automatic pop(int s, output logic [31:0] d);
    d = popData[s];
    popEn[s] = 1'b1;
    @(negedge clk);
    popEn[s] = 1'b0;
  endtask

  task automatic pushPop(int s, logic [31:0] din, output logic [31:0] dout);
    dout = popData[s];
    pushEn[s] = 1'b1; popEn[s] = 1'b1; pushData[s] = din;
    @(negedge clk);
    pushEn[s] = 1'b0; popEn[s] = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] got;
    int bad;
    opWrEn = '0; ctrlWrEn = '0; pushEn = '0; popEn = '0;
    for (int s = 0; s < 2; s++) begin
      opData[s] = '0; ctrlData[s] = '0; pushData[s] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", 32'(statusWord[0]), 32'h200);
    check("R1 overflow", 32'(evOverflow[0]), 32'h0);
    check("R1 rx threshold", 32'(evThreshold[0]), 32'h0);
    // R7 stopped after reset: push ignored
    push(0, 32'h11);
    check("R7 push while stopped", 32'(statusWord[0]), 32'h200);

    // vector table: R2 / R3 width handling and zero extension
    for (int i = 0; i < 8; i++) begin
      automatic logic [65:0] v = VEC[i];
      ctrlWrite(0, v[65:64], 8'd128);
      opWrite(0, 1'b1, 1'b1);
      push(0, v[63:32]);
      check("R3 level one entry", 32'(statusWord[0]), 32'h001);
      pop(0, got);
      check("R2 popped value", got, v[31:0]);
      check("R2 empty after pop", 32'(statusWord[0]), 32'h200);
    end

    // byte fill: R10, R4, R8, R9
    ctrlWrite(0, 2'd0, 8'd128);
    opWrite(0, 1'b1, 1'b1);
    for (int i = 0; i < 256; i++) begin
      push(0, 32'(i));
      if (i == 126) check("R10 rx below threshold", 32'(evThreshold[0]), 32'h0);
      if (i == 127) check("R10 rx at threshold", 32'(evThreshold[0]), 32'h1);
    end
    check("R4 byte full status", 32'(statusWord[0]), 32'h100);
    check("R9 no overflow yet", 32'(evOverflow[0]), 32'h0);
    push(0, 32'hEE);
    check("R8 push when full", 32'(statusWord[0]), 32'h100);
    check("R9 overflow set", 32'(evOverflow[0]), 32'h1);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      pop(0, got);
      if (got !== 32'(i & 8'hFF)) bad++;
    end
    check("R2 R8 drain order mismatches", 32'(bad), 32'h0);
    check("R8 drained empty", 32'(statusWord[0]), 32'h200);
    pop(0, got);
    check("R8 pop when empty", 32'(statusWord[0]), 32'h200);
    check("R9 overflow sticky", 32'(evOverflow[0]), 32'h1);
    opWrite(0, 1'b1, 1'b1);
    check("R6 clear drops overflow", 32'(evOverflow[0]), 32'h0);

    // R3 full points for wide entries
    ctrlWrite(0, 2'd2, 8'd128);
    opWrite(0, 1'b1, 1'b1);
    for (int i = 0; i < 64; i++) push(0, 32'(i));
    check("R3 dword full at 64", 32'(statusWord[0]), 32'h140);
    ctrlWrite(0, 2'd1, 8'd128);
    opWrite(0, 1'b1, 1'b1);
    for (int i = 0; i < 128; i++) push(0, 32'(i));
    check("R3 halfword full at 128", 32'(statusWord[0]), 32'h180);

    // R5 width change waits for clear
    ctrlWrite(0, 2'd0, 8'd128);
    opWrite(0, 1'b1, 1'b1);
    push(0, 32'hAB);
    ctrlWrite(0, 2'd2, 8'd128);
    push(0, 32'h12345678);
    check("R5 level two bytes", 32'(statusWord[0]), 32'h002);
    pop(0, got);
    check("R5 first byte", got, 32'hAB);
    pop(0, got);
    check("R5 old width kept", got, 32'h78);
    opWrite(0, 1'b1, 1'b1);
    push(0, 32'h12345678);
    pop(0, got);
    check("R5 new width after clear", got, 32'h12345678);

    // R6 / R7 stop and restart
    push(0, 32'h1);
    push(0, 32'h2);
    opWrite(0, 1'b0, 1'b0);
    push(0, 32'h3);
    check("R7 push ignored while stopped", 32'(statusWord[0]), 32'h002);
    pop(0, got);
    check("R7 pop ignored while stopped", 32'(statusWord[0]), 32'h002);
    opWrite(0, 1'b0, 1'b1);
    pop(0, got);
    check("R6 content kept over stop", got, 32'h1);

    // R11 simultaneous push and pop
    push(0, 32'h3);
    pushPop(0, 32'h4, got);
    check("R11 head popped", got, 32'h2);
    check("R11 level unchanged", 32'(statusWord[0]), 32'h002);
    pop(0, got);
    check("R11 order a", got, 32'h3);
    pop(0, got);
    check("R11 order b", got, 32'h4);

    // transmit flavour: R1, R10, R9
    check("R1 tx status", 32'(statusWord[1]), 32'h200);
    check("R10 tx threshold at empty", 32'(evThreshold[1]), 32'h1);
    ctrlWrite(1, 2'd0, 8'd2);
    opWrite(1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) push(1, 32'(i));
    check("R10 tx above threshold", 32'(evThreshold[1]), 32'h0);
    pop(1, got);
    check("R10 tx at threshold", 32'(evThreshold[1]), 32'h1);
    ctrlWrite(1, 2'd2, 8'd2);
    opWrite(1, 1'b1, 1'b1);
    for (int i = 0; i < 65; i++) push(1, 32'(i));
    check("R9 tx full status", 32'(statusWord[1]), 32'h140);
    check("R9 tx never overflows", 32'(evOverflow[1]), 32'h0);

    finishRun();
  end

endmodule